// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block holds the combinational control decoding for a single-cycle processor core. It takes the 6-bit primary opcode of the current instruction and the 6-bit function field. From these it produces the datapath steering signals, the write enables and a 3-bit operation code for the arithmetic unit. It has no state: every output settles within the same cycle as its inputs.

Decoding runs in two levels. The first level looks at the opcode alone. It produces the multiplexer selects, the enables and a 2-bit class code that tells the second level how to pick the arithmetic operation. The second level sees only that class code and the function field. For register-register instructions the function field chooses the operation. For memory and branch instructions the class code forces an add or a subtract. The two mux selects follow single opcode bits directly. Each enable is qualified by a check that the opcode is one of the four supported encodings, so an unsupported opcode cannot write anything.

Top module: `ctrl_decode_top`

## Requirements
- R1: The class output `alu_class_o` is 2'b10 for register-register, 2'b00 for load and store, 2'b01 for branch-if-equal, and 2'b00 for any unsupported opcode.
- R2: Four opcode values are supported: register-register 6'b000000, load word 6'b100011, store word 6'b101011, branch-if-equal 6'b000100; every other value is unsupported.
- R3: `dst_sel_o` equals the inverse of opcode bit 0 for every opcode value (1 picks the rd field as write target).
- R4: `imm_sel_o` equals opcode bit 0 for every opcode value (1 picks the sign-extended immediate as second operand).
- R5: `rf_we_o` is 1 for register-register and load word and 0 for store word and branch-if-equal.
- R6: `dm_we_o` is 1 only for store word, `load_sel_o` is 1 only for load word, and `branch_o` is 1 only for branch-if-equal.
- R7: For any unsupported opcode, `rf_we_o`, `dm_we_o`, `load_sel_o` and `branch_o` are all 0.
- R8: When the class is 2'b00, `alu_ctl_o` is 3'b010 (add); when it is 2'b01, `alu_ctl_o` is 3'b110 (subtract); the function field has no effect in either case.
- R9: When the class is 2'b10, the function field maps 6'b100000 to 3'b010, 6'b100010 to 3'b110, 6'b100100 to 3'b000, 6'b100101 to 3'b001 and 6'b101010 to 3'b111.
- R10: When the class is 2'b10 and the function field is any other value, `alu_ctl_o` is 3'b011, a code no listed operation uses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Primary opcode of the instruction |
| funct_i | input | 6 | Function field of the instruction |
| dst_sel_o | output | 1 | Write-target select: 1 = rd field, 0 = rt field |
| imm_sel_o | output | 1 | Second-operand select: 1 = immediate, 0 = register |
| load_sel_o | output | 1 | Write-back select: 1 = memory data, 0 = ALU result |
| rf_we_o | output | 1 | Register file write enable |
| dm_we_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Instruction is a conditional branch |
| alu_class_o | output | 2 | Class code passed from the first level to the second |
| alu_ctl_o | output | 3 | Operation code for the arithmetic unit |

## Verification
The checks assume that both input fields hold known 0/1 values. Each check is skipped while any input bit is unknown, and the stimulus drives defined values from the first cycle on. Besides that, the checks assume only that the second level is fed by the first level's class code, which the top wires internally. The stimulus sweeps every combination of opcode and function field, so every unsupported opcode and every unlisted function code is covered next to the supported ones.

// File: rtl/ctrl_decode_pkg.sv
package ctrl_decode_pkg;

  localparam int unsigned OP_W    = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned CLASS_W = 2;
  localparam int unsigned CTL_W   = 3;

  localparam logic [OP_W-1:0] OPC_RRR  = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STOR = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'b000100;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [CLASS_W-1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_RSVD  = 2'b11
  } alu_class_e;

  typedef enum logic [CTL_W-1:0] {
    ALU_AND  = 3'b000,
    ALU_OR   = 3'b001,
    ALU_ADD  = 3'b010,
    ALU_NONE = 3'b011,
    ALU_SUB  = 3'b110,
    ALU_SLT  = 3'b111
  } alu_ctl_e;

  typedef struct packed {
    logic       dst_sel;
    logic       imm_sel;
    logic       load_sel;
    logic       rf_we;
    logic       dm_we;
    logic       branch;
    alu_class_e alu_class;
  } main_ctl_t;

endpackage

// File: rtl/ctrl_op_classify.sv
module ctrl_op_classify
  import ctrl_decode_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            known_o,
  output logic            is_rrr_o,
  output logic            is_load_o,
  output logic            is_store_o,
  output logic            is_beq_o
);

  always_comb begin
    is_rrr_o   = (op_i == OPC_RRR);
    is_load_o  = (op_i == OPC_LOAD);
    is_store_o = (op_i == OPC_STOR);
    is_beq_o   = (op_i == OPC_BEQ);
    known_o    = is_rrr_o | is_load_o | is_store_o | is_beq_o;
  end

endmodule

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_decode_pkg::*;
#(
  parameter bit BIT_REDUCED = 1'b1
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            known_i,
  input  logic            is_rrr_i,
  input  logic            is_load_i,
  input  logic            is_store_i,
  input  logic            is_beq_i,
  output main_ctl_t       ctl_o
);

  // Mux selects follow single opcode bits whatever the opcode is.
  always_comb begin
    ctl_o.dst_sel = ~op_i[0];
    ctl_o.imm_sel =  op_i[0];
  end

  generate
    if (BIT_REDUCED) begin : g_reduced
      // Within the four supported encodings, a few opcode bits separate
      // every enable; the legality flag blocks all other opcodes.
      always_comb begin
        ctl_o.rf_we     = known_i & ~op_i[3] & ~op_i[2];
        ctl_o.dm_we     = known_i &  op_i[3];
        ctl_o.load_sel  = known_i &  op_i[5] & ~op_i[3];
        ctl_o.branch    = known_i &  op_i[2];
        ctl_o.alu_class = alu_class_e'({known_i & ~op_i[5] & ~op_i[2],
                                        known_i &  op_i[2]});
      end
    end else begin : g_table
      always_comb begin
        ctl_o.rf_we     = is_rrr_i | is_load_i;
        ctl_o.dm_we     = is_store_i;
        ctl_o.load_sel  = is_load_i;
        ctl_o.branch    = is_beq_i;
        if (is_rrr_i)      ctl_o.alu_class = CLS_FUNCT;
        else if (is_beq_i) ctl_o.alu_class = CLS_SUB;
        else               ctl_o.alu_class = CLS_ADD;
      end
    end
  endgenerate

endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_decode_pkg::*;
(
  input  alu_class_e      class_i,
  input  logic [FN_W-1:0] funct_i,
  output alu_ctl_e        ctl_o
);

  alu_ctl_e fn_ctl;

  always_comb begin
    unique case (funct_i)
      FN_ADD:  fn_ctl = ALU_ADD;
      FN_SUB:  fn_ctl = ALU_SUB;
      FN_AND:  fn_ctl = ALU_AND;
      FN_OR:   fn_ctl = ALU_OR;
      FN_SLT:  fn_ctl = ALU_SLT;
      default: fn_ctl = ALU_NONE;
    endcase
  end

  always_comb begin
    unique case (class_i)
      CLS_ADD:   ctl_o = ALU_ADD;
      CLS_SUB:   ctl_o = ALU_SUB;
      CLS_FUNCT: ctl_o = fn_ctl;
      default:   ctl_o = ALU_NONE;
    endcase
  end

endmodule

// File: rtl/ctrl_decode_top.sv
module ctrl_decode_top
  import ctrl_decode_pkg::*;
#(
  parameter bit BIT_REDUCED = 1'b1
) (
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output logic       dst_sel_o,
  output logic       imm_sel_o,
  output logic       load_sel_o,
  output logic       rf_we_o,
  output logic       dm_we_o,
  output logic       branch_o,
  output logic [1:0] alu_class_o,
  output logic [2:0] alu_ctl_o
);

  logic      known, is_rrr, is_load, is_store, is_beq;
  main_ctl_t main_ctl;
  alu_ctl_e  alu_ctl;

  ctrl_op_classify u_cls (
    .op_i       (op_i),
    .known_o    (known),
    .is_rrr_o   (is_rrr),
    .is_load_o  (is_load),
    .is_store_o (is_store),
    .is_beq_o   (is_beq)
  );

  ctrl_main_dec #(.BIT_REDUCED(BIT_REDUCED)) u_main (
    .op_i       (op_i),
    .known_i    (known),
    .is_rrr_i   (is_rrr),
    .is_load_i  (is_load),
    .is_store_i (is_store),
    .is_beq_i   (is_beq),
    .ctl_o      (main_ctl)
  );

  ctrl_alu_dec u_alu (
    .class_i (main_ctl.alu_class),
    .funct_i (funct_i),
    .ctl_o   (alu_ctl)
  );

  always_comb begin
    dst_sel_o   = main_ctl.dst_sel;
    imm_sel_o   = main_ctl.imm_sel;
    load_sel_o  = main_ctl.load_sel;
    rf_we_o     = main_ctl.rf_we;
    dm_we_o     = main_ctl.dm_we;
    branch_o    = main_ctl.branch;
    alu_class_o = main_ctl.alu_class;
    alu_ctl_o   = alu_ctl;
  end

endmodule

// File: rtl/ctrl_decode_chk.sv
module ctrl_decode_chk (
  input logic [5:0] op_i,
  input logic [5:0] funct_i,
  input logic       dst_sel_o,
  input logic       imm_sel_o,
  input logic       load_sel_o,
  input logic       rf_we_o,
  input logic       dm_we_o,
  input logic       branch_o,
  input logic [1:0] alu_class_o,
  input logic [2:0] alu_ctl_o
);

  logic inputs_known;
  logic op_supported;

  always_comb begin
    inputs_known = !$isunknown({op_i, funct_i});
    op_supported = (op_i == 6'b000000) || (op_i == 6'b100011) ||
                   (op_i == 6'b101011) || (op_i == 6'b000100);
  end

  always_comb begin
    if (inputs_known) begin
      assert_dst_follows_bit0_R3: assert (dst_sel_o == !op_i[0])
        else $error("dst select does not track opcode bit 0");
      assert_imm_follows_bit0_R4: assert (imm_sel_o == op_i[0])
        else $error("immediate select does not track opcode bit 0");
      assert_store_no_rf_write_R5: assert (!(dm_we_o && rf_we_o))
        else $error("store also writes the register file");
      assert_single_special_R6: assert ($onehot0({dm_we_o, load_sel_o, branch_o}))
        else $error("more than one of store, load, branch active");
      assert_unsupported_quiet_R7: assert (op_supported ||
          (!rf_we_o && !dm_we_o && !load_sel_o && !branch_o && alu_class_o == 2'b00))
        else $error("unsupported opcode drives an enable");
      assert_branch_class_R1: assert (!branch_o || alu_class_o == 2'b01)
        else $error("branch without subtract class");
      assert_fixed_class_ctl_R8: assert (alu_class_o == 2'b10 ||
          alu_ctl_o == ((alu_class_o == 2'b01) ? 3'b110 : 3'b010) || alu_class_o == 2'b11)
        else $error("fixed class gives wrong operation code");
    end
  end

endmodule

bind ctrl_decode_top ctrl_decode_chk u_chk (
  .op_i        (op_i),
  .funct_i     (funct_i),
  .dst_sel_o   (dst_sel_o),
  .imm_sel_o   (imm_sel_o),
  .load_sel_o  (load_sel_o),
  .rf_we_o     (rf_we_o),
  .dm_we_o     (dm_we_o),
  .branch_o    (branch_o),
  .alu_class_o (alu_class_o),
  .alu_ctl_o   (alu_ctl_o)
);

// File: tb/ctrl_decode_top_tb_top.sv
module ctrl_decode_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] op_i = '0;
  logic [5:0] funct_i = '0;
  logic       dst_sel_o, imm_sel_o, load_sel_o, rf_we_o, dm_we_o, branch_o;
  logic [1:0] alu_class_o;
  logic [2:0] alu_ctl_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_decode_top dut_i (
    .op_i        (op_i),
    .funct_i     (funct_i),
    .dst_sel_o   (dst_sel_o),
    .imm_sel_o   (imm_sel_o),
    .load_sel_o  (load_sel_o),
    .rf_we_o     (rf_we_o),
    .dm_we_o     (dm_we_o),
    .branch_o    (branch_o),
    .alu_class_o (alu_class_o),
    .alu_ctl_o   (alu_ctl_o)
  );

  task automatic check(input string req, input int act, input int exp,
                       input int op, input int fn);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s op=%b funct=%b actual=%0d expected=%0d",
               req, op[5:0], fn[5:0], act, exp);
    end
  endtask

  // Reference model built from the requirement list.
  task automatic compare_all(input int op, input int fn);
    int  cls, ctl;
    bit  rrr, ld, st, bq, sup;
    rrr = (op == 0);  ld = (op == 35);  st = (op == 43);  bq = (op == 4);
    sup = rrr || ld || st || bq;
    cls = rrr ? 2 : (bq ? 1 : 0);
    if (cls == 1)      ctl = 6;
    else if (cls == 0) ctl = 2;
    else begin
      case (fn)
        32: ctl = 2;  34: ctl = 6;  36: ctl = 0;
        37: ctl = 1;  42: ctl = 7;  default: ctl = 3;
      endcase
    end
    check("R3", int'(dst_sel_o), (op % 2 == 0) ? 1 : 0, op, fn);
    check("R4", int'(imm_sel_o), op % 2, op, fn);
    check(sup ? "R1" : "R7", int'(alu_class_o), cls, op, fn);
    check(sup ? "R5" : "R7", int'(rf_we_o), (rrr || ld) ? 1 : 0, op, fn);
    check(sup ? "R6" : "R7", int'(dm_we_o), st ? 1 : 0, op, fn);
    check(sup ? "R6" : "R7", int'(load_sel_o), ld ? 1 : 0, op, fn);
    check(sup ? "R6" : "R7", int'(branch_o), bq ? 1 : 0, op, fn);
    check(cls != 2 ? "R8" : (ctl == 3 ? "R10" : "R9"), int'(alu_ctl_o), ctl, op, fn);
    // R2: supported and unsupported opcodes separated by the enable set
    check("R2", int'(rf_we_o | dm_we_o | branch_o), sup ? 1 : 0, op, fn);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // State after reset: R-format add applied
    @(posedge clk);
    op_i = 6'b000000; funct_i = 6'b100000;
    @(negedge clk);
    check("R9", int'(alu_ctl_o), 2, 0, 32);
    check("R5", int'(rf_we_o), 1, 0, 32);
    // Directed neighbours of store: 101010 must stay unsupported (R2)
    @(posedge clk);
    op_i = 6'b101010; funct_i = 6'b100010;
    @(negedge clk);
    check("R2", int'(dm_we_o), 0, 42, 34);
    // Full sweep of opcode and function field
    for (int o = 0; o < 64; o++) begin
      for (int f = 0; f < 64; f++) begin
        @(posedge clk);
        op_i = 6'(o); funct_i = 6'(f);
        @(negedge clk);
        compare_all(o, f);
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule